// File: doc/BRIEF.md
# Link event statistics counters

This unit keeps running totals for a serial link. A 16-bit counter records how often the link has been switched on. Eight more 16-bit counters record how often each of eight interrupt sources has fired. The interrupt counters take the raw event pulses, so a source counts whether or not software has masked it. Software reads the totals through a simple word-addressed register port, and it can zero every total at once by writing a single control bit.

The interrupt totals are packed two to a 32-bit word, and the four words sit at consecutive addresses. All counters stop at their maximum value rather than rolling over. A read returns its data one clock after the request and holds that value until the next read.

Top module: `evt_stats`

## Requirements
- R1: After reset every counter is zero and `rd_data` reads zero.
- R2: The link counter adds one on each 0-to-1 change of `link_en`, sampled at the clock. A level held high for many cycles counts once. A level that is already high when reset ends counts as one enable.
- R3: Each interrupt counter adds one for every clock cycle in which its `irq_evt` bit is high. Each source counts independently of the others, and no mask is involved.
- R4: Word address 0x0B4+k holds source 2k in bits 15:0 and source 2k+1 in bits 31:16, for k = 0 to 3.
- R5: Word address 0x0B1 returns the link count in bits 15:0, with bits 31:16 at zero.
- R6: A write to word address 0x0B0 with data bit 0 set zeroes every counter at that clock edge. A write to 0x0B0 with bit 0 clear, or a write to any other address, leaves every counter unchanged.
- R7: A clear and an increment in the same cycle leave the counter at zero.
- R8: Reading address 0x0B0 returns zero, so the clear bit reads back as 0.
- R9: A counter that has reached 0xFFFF stays at 0xFFFF on further events until it is cleared.
- R10: `rd_data` shows the word addressed by a read in the cycle after `rd_en`. It holds that value while `rd_en` is low. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Link enable level |
| irq_evt | input | 8 | Raw interrupt event pulses, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Register read word address |
| rd_data | output | 32 | Registered read data |

## Verification
The assertions make several assumptions about the inputs:
- The clear condition is fully described by the write port in the same cycle.
- An idle `irq_evt` bit means no event.
- A low `link_en` can never produce an enable edge.

The stimulus changes every input one time unit after a rising edge. This keeps each input stable across the sampling edge, and each write or read strobe lasts exactly one cycle. Events are held for exact cycle counts so that the bench's model can total them. The run holds `link_en` high across a clear only on purpose, to test clear priority.

// File: rtl/evt_stats_pkg.sv
package evt_stats_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_LINK,
    SEL_IRQ
  } sel_e;
endpackage

// File: rtl/evt_stats_edge.sv
module evt_stats_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/evt_stats_cnt.sv
module evt_stats_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  // clear wins over increment; stop at the top value
  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/evt_stats_rdmux.sv
module evt_stats_rdmux
  import evt_stats_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned N_SRC     = 8,
  parameter int unsigned CTRL_ADDR = 12'h0B0,
  parameter int unsigned IRQ_BASE  = 12'h0B4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [CNT_W-1:0]         link_cnt,
  input  logic [N_SRC*CNT_W-1:0]   irq_cnt,
  output logic [BUS_W-1:0]         rd_data
);
  localparam int unsigned PER_WORD = BUS_W / CNT_W;
  localparam int unsigned N_WORDS  = (N_SRC + PER_WORD - 1) / PER_WORD;
  localparam int unsigned IDX_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic [N_WORDS*BUS_W-1:0] irq_words;
  sel_e                     sel;
  logic [IDX_W-1:0]         idx;
  logic [BUS_W-1:0]         nxt;

  always_comb begin
    irq_words = '0;
    irq_words[N_SRC*CNT_W-1:0] = irq_cnt;
  end

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (rd_addr == ADDR_W'(CTRL_ADDR))          sel = SEL_CTRL;
    else if (rd_addr == ADDR_W'(CTRL_ADDR + 1)) sel = SEL_LINK;
    else begin
      for (int k = 0; k < N_WORDS; k++) begin
        if (rd_addr == ADDR_W'(IRQ_BASE + k)) begin
          sel = SEL_IRQ;
          idx = IDX_W'(k);
        end
      end
    end
  end

  always_comb begin
    nxt = '0;
    case (sel)
      SEL_LINK: nxt[CNT_W-1:0] = link_cnt;
      SEL_IRQ:  nxt = irq_words[idx*BUS_W +: BUS_W];
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= nxt;
  end
endmodule

// File: rtl/evt_stats.sv
module evt_stats
  import evt_stats_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned N_SRC     = 8,
  parameter int unsigned CTRL_ADDR = 12'h0B0,
  parameter int unsigned IRQ_BASE  = 12'h0B4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_en,
  input  logic [N_SRC-1:0]  irq_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data
);
  logic                   clr_hit;
  logic                   link_rise;
  logic [CNT_W-1:0]       link_cnt_q;
  logic [N_SRC*CNT_W-1:0] irq_cnt_q;
  logic                   unused_wr_bits;

  assign clr_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)) && wr_data[0];
  assign unused_wr_bits = ^wr_data[BUS_W-1:1];

  evt_stats_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (link_en),
    .rise (link_rise)
  );

  evt_stats_cnt #(.W(CNT_W)) u_link_cnt (
    .clk (clk),
    .rst (rst),
    .clr (clr_hit),
    .inc (link_rise),
    .cnt (link_cnt_q)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_irq
    evt_stats_cnt #(.W(CNT_W)) u_irq_cnt (
      .clk (clk),
      .rst (rst),
      .clr (clr_hit),
      .inc (irq_evt[i]),
      .cnt (irq_cnt_q[i*CNT_W +: CNT_W])
    );
  end

  evt_stats_rdmux #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .N_SRC     (N_SRC),
    .CTRL_ADDR (CTRL_ADDR),
    .IRQ_BASE  (IRQ_BASE)
  ) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .link_cnt (link_cnt_q),
    .irq_cnt  (irq_cnt_q),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/evt_stats_chk.sv
module evt_stats_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned N_SRC     = 8,
  parameter int unsigned CTRL_ADDR = 12'h0B0
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   link_en,
  input logic [N_SRC-1:0]       irq_evt,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [31:0]            wr_data,
  input logic                   rd_en,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic [31:0]            rd_data,
  input logic [CNT_W-1:0]       link_cnt,
  input logic [N_SRC*CNT_W-1:0] irq_cnt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic clr_seen;
  assign clr_seen = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)) && wr_data[0];

  // R6
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
    clr_seen |=> (link_cnt == '0 && irq_cnt == '0));

  // R2
  link_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_seen && !link_en) |=> $stable(link_cnt));

  // R2
  link_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_seen |=> (link_cnt == $past(link_cnt) || link_cnt == $past(link_cnt) + 1'b1));

  // R9
  link_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_seen && link_cnt == TOP) |=> link_cnt == TOP);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    // R3
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr_seen && !irq_evt[i]) |=> $stable(irq_cnt[i*CNT_W +: CNT_W]));

    // R3
    irq_inc_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr_seen && irq_evt[i] && irq_cnt[i*CNT_W +: CNT_W] != TOP)
      |=> irq_cnt[i*CNT_W +: CNT_W] == $past(irq_cnt[i*CNT_W +: CNT_W]) + 1'b1);

    // R9
    irq_sat_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr_seen && irq_cnt[i*CNT_W +: CNT_W] == TOP)
      |=> irq_cnt[i*CNT_W +: CNT_W] == TOP);
  end

  // R8
  ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(CTRL_ADDR)) |=> rd_data == '0);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind evt_stats evt_stats_chk #(
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .N_SRC     (N_SRC),
  .CTRL_ADDR (CTRL_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .link_en  (link_en),
  .irq_evt  (irq_evt),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .link_cnt (link_cnt_q),
  .irq_cnt  (irq_cnt_q)
);

// File: tb/tb_evt_stats.sv
module tb_evt_stats;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC      = 8;
  localparam int ADDR_W     = 12;
  localparam logic [ADDR_W-1:0] A_CTRL = 12'h0B0;
  localparam logic [ADDR_W-1:0] A_LINK = 12'h0B1;
  localparam logic [ADDR_W-1:0] A_IRQ  = 12'h0B4;

  // {pattern[47:40], cycles[39:32], expected word 0x0B4 [31:0]}
  localparam int N_VEC = 5;
  localparam logic [47:0] VEC [N_VEC] = '{
    {8'h01, 8'd3, 32'h0000_0003},
    {8'h02, 8'd2, 32'h0002_0003},
    {8'h03, 8'd4, 32'h0006_0007},
    {8'hF0, 8'd5, 32'h0006_0007},
    {8'hFF, 8'd1, 32'h0007_0008}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              link_en;
  logic [N_SRC-1:0]  irq_evt;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [31:0]       rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int m_irq [N_SRC];
  int m_link;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_stats dut (
    .clk(clk), .rst(rst), .link_en(link_en), .irq_evt(irq_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int sat(input int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [N_SRC-1:0] pat, input int reps);
    irq_evt = pat;
    repeat (reps) @(posedge clk);
    #1 irq_evt = '0;
    for (int i = 0; i < N_SRC; i++)
      if (pat[i]) m_irq[i] = sat(m_irq[i] + reps);
  endtask

  task automatic model_clear();
    for (int i = 0; i < N_SRC; i++) m_irq[i] = 0;
    m_link = 0;
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    for (int k = 0; k < N_SRC/2; k++) begin
      rd(A_IRQ + ADDR_W'(k), d);
      check(req, d, {16'(m_irq[2*k+1]), 16'(m_irq[2*k])});
    end
    rd(A_LINK, d);
    check(req, d, {16'h0, 16'(m_link)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; link_en = 1'b0; irq_evt = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_en = 1'b0; rd_addr = '0;
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    check("R1", rd_data, 32'h0);
    check_all("R1");

    // R3 / R4: table of event patterns, cumulative totals
    for (int v = 0; v < N_VEC; v++) begin
      pulse(VEC[v][47:40], int'(VEC[v][39:32]));
      rd(A_IRQ, d);
      check("R3", d, VEC[v][31:0]);
      check_all("R4");
    end

    // R2 / R5: three short enables, then one long one
    for (int t = 0; t < 3; t++) begin
      link_en = 1'b1; @(posedge clk); #1;
      link_en = 1'b0; @(posedge clk); #1;
      m_link++;
    end
    link_en = 1'b1;
    repeat (10) @(posedge clk);
    #1 link_en = 1'b0;
    m_link++;
    rd(A_LINK, d);
    check("R2", d, 32'd4);
    check_all("R5");

    // R6: writes that must not clear
    wr(A_CTRL, 32'hFFFF_FFFE);
    check_all("R6");
    wr(A_LINK, 32'h0000_0001);
    wr(12'h0B5, 32'h0000_0001);
    check_all("R6");

    // R8: control reads zero
    rd(A_CTRL, d);
    check("R8", d, 32'h0);

    // R10: unmapped reads zero
    rd(12'h0B2, d);
    check("R10", d, 32'h0);
    rd(12'h000, d);
    check("R10", d, 32'h0);

    // R6: clear zeroes everything
    wr(A_CTRL, 32'h0000_0001);
    model_clear();
    check_all("R6");

    // R7: clear wins over same-cycle increment
    irq_evt = '1; link_en = 1'b1;
    wr_en = 1'b1; wr_addr = A_CTRL; wr_data = 32'h1;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0; irq_evt = '0; link_en = 1'b0;
    check_all("R7");

    // R10: one-cycle latency, then hold while rd_en low
    pulse(8'h01, 2);
    rd(A_IRQ, d);
    check("R10", d, 32'h0000_0002);
    rd_addr = A_LINK;
    @(posedge clk); #1;
    check("R10", rd_data, 32'h0000_0002);

    // R9: saturation
    pulse(8'h80, 65540);
    check_all("R9");
    pulse(8'h80, 3);
    rd(A_IRQ + 12'd3, d);
    check("R9", d, 32'hFFFF_0000);

    // R6: clear after saturation
    wr(A_CTRL, 32'h0000_0001);
    model_clear();
    check_all("R6");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule